// File: doc/BRIEF.md
# Modulo 2^n-1 Parallel-Prefix Adder

This block adds two residues modulo 2^n-1 in a single combinational pass. It is meant to sit at the end of a residue-to-binary conversion path, where the last operation is an addition in the 2^n-1 channel. A plain n-bit parallel-prefix adder with no carry-in forms the raw binary sum. A separate excess-one unit then finishes the modular sum by adding one when the prefix network reports that the addition wrapped.

The block has three arithmetic stages: per-bit generate/propagate formation, a prefix carry network, and a sum stage. A build parameter selects the network. Kogge-Stone gives the fewest levels and Brent-Kung gives the fewest combine cells. Both settings give the same result bit for bit. The end-around carry is never fed back through an extra prefix level. Instead the whole-word group generate and group propagate drive a conditional increment, and the output always uses a single code for zero.

There is no state machine. The block has no clock and no state, and the output follows the operands within the same cycle.

Top module: `mres_adder`

## Requirements
- R1: For operands a, b each below 2^n-1, s equals (a + b) mod (2^n-1).
- R2: The all-ones pattern never appears on s, so zero has one code only.
- R3: When both operands are zero, s is zero.
- R4: When a + b equals exactly 2^n-1 (raw sum all ones, no carry-out), s is zero.
- R5: When the binary sum carries out of bit n-1, s equals the low n bits of the sum plus one. For example, with both operands at 2^n-2, s is 2^n-3.
- R6: An operand equal to all ones (2^n-1) acts as an alternative zero code, so s equals the other operand reduced mod 2^n-1.
- R7: When both operands are all ones, s is zero.
- R8: Parameter NET_SEL chooses the prefix network: 0 selects Kogge-Stone and 1 selects Brent-Kung. For every operand pair, both settings produce identical s.
- R9: The block is purely combinational. s reflects new operands within the same clock period, with no clock or reset port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First residue operand |
| b | input | WIDTH | Second residue operand |
| s | output | WIDTH | Sum modulo 2^WIDTH-1, never all ones |

## Verification
The assertions inside the block assume that both operands are stable 2-state values whenever the combinational checks evaluate. The assertions also assume that WIDTH is small enough for the arithmetic cross-check to fit in 64 bits. The stimulus changes the operands only shortly after a clock edge and reads the result at the opposite edge, so every comparison sees settled logic. The random operands span the full n-bit range, including the all-ones zero code. This means the assertions about carry, all-ones raw sums and zero folding are all exercised on legal inputs.

// File: rtl/mres_pkg.sv
package mres_pkg;
    localparam int NET_KS = 0;
    localparam int NET_BK = 1;

    function automatic int prefix_levels(input int n);
        int lv;
        lv = 0;
        while ((1 << lv) < n) lv++;
        return (lv < 1) ? 1 : lv;
    endfunction
endpackage

// File: rtl/mres_pg_pre.sv
module mres_pg_pre #(
    parameter int N = 16
) (
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    output logic [N-1:0] bit_g,
    output logic [N-1:0] bit_p
);
    assign bit_g = op_x & op_y;
    assign bit_p = op_x ^ op_y;
endmodule

// File: rtl/mres_prefix_net.sv
module mres_prefix_net
    import mres_pkg::*;
#(
    parameter int N       = 16,
    parameter int NET_SEL = NET_KS
) (
    input  logic [N-1:0] bit_g,
    input  logic [N-1:0] bit_p,
    output logic [N-1:0] grp_g,
    output logic [N-1:0] grp_p
);
    localparam int LV = prefix_levels(N);

    generate
        if (NET_SEL == NET_KS) begin : g_kogge
            logic [N-1:0] gs [0:LV];
            logic [N-1:0] ps [0:LV];
            assign gs[0] = bit_g;
            assign ps[0] = bit_p;
            for (genvar k = 0; k < LV; k++) begin : g_lvl
                for (genvar i = 0; i < N; i++) begin : g_bit
                    if (i >= (1 << k)) begin : g_cell
                        assign gs[k+1][i] = gs[k][i] | (ps[k][i] & gs[k][i-(1<<k)]);
                        assign ps[k+1][i] = ps[k][i] & ps[k][i-(1<<k)];
                    end else begin : g_pass
                        assign gs[k+1][i] = gs[k][i];
                        assign ps[k+1][i] = ps[k][i];
                    end
                end
            end
            assign grp_g = gs[LV];
            assign grp_p = ps[LV];
        end else begin : g_brent
            localparam int ST = 2 * LV - 1;
            logic [N-1:0] gs [0:ST];
            logic [N-1:0] ps [0:ST];
            assign gs[0] = bit_g;
            assign ps[0] = bit_p;
            for (genvar k = 0; k < LV; k++) begin : g_up
                for (genvar i = 0; i < N; i++) begin : g_bit
                    if (((i + 1) % (2 << k)) == 0) begin : g_cell
                        assign gs[k+1][i] = gs[k][i] | (ps[k][i] & gs[k][i-(1<<k)]);
                        assign ps[k+1][i] = ps[k][i] & ps[k][i-(1<<k)];
                    end else begin : g_pass
                        assign gs[k+1][i] = gs[k][i];
                        assign ps[k+1][i] = ps[k][i];
                    end
                end
            end
            for (genvar k = LV - 2; k >= 0; k--) begin : g_dn
                localparam int SI = LV + (LV - 2 - k);
                for (genvar i = 0; i < N; i++) begin : g_bit
                    if ((((i + 1) % (2 << k)) == (1 << k)) && ((i + 1) > (1 << k))) begin : g_cell
                        assign gs[SI+1][i] = gs[SI][i] | (ps[SI][i] & gs[SI][i-(1<<k)]);
                        assign ps[SI+1][i] = ps[SI][i] & ps[SI][i-(1<<k)];
                    end else begin : g_pass
                        assign gs[SI+1][i] = gs[SI][i];
                        assign ps[SI+1][i] = ps[SI][i];
                    end
                end
            end
            assign grp_g = gs[ST];
            assign grp_p = ps[ST];
        end
    endgenerate
endmodule

// File: rtl/mres_excess_one.sv
module mres_excess_one #(
    parameter int N = 16
) (
    input  logic [N-1:0] raw,
    input  logic         carry_out,
    input  logic [N-1:0] grp_p,
    output logic [N-1:0] res
);
    logic [N-1:0] low_and;
    logic [N-1:0] incr;
    logic         bump;
    logic         fold;

    assign low_and[0] = 1'b1;
    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign low_and[i] = low_and[i-1] & raw[i-1];
        end
    endgenerate

    assign incr = raw ^ low_and;
    assign bump = carry_out | grp_p[N-1];
    assign fold = carry_out & (&raw[N-1:1]);
    assign res  = !bump ? raw : (fold ? '0 : incr);

    always_comb begin
        assert_single_zero_R2: assert (res != {N{1'b1}});
        assert_no_wrap_pass_R1: assert (bump || (res == raw));
        assert_end_around_R5: assert (!(carry_out && !fold) || (res == raw + 1'b1));
        assert_prop_excl_R4: assert (!(carry_out && grp_p[N-1]));
        assert_allones_zero_R4: assert (!grp_p[N-1] || (res == '0));
        for (int i = 0; i < N; i++) begin
            assert_prop_chain_R1: assert (!grp_p[i] || (&(raw | ~({N{1'b1}} >> (N-1-i)))));
        end
    end
endmodule

// File: rtl/mres_adder.sv
module mres_adder
    import mres_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int NET_SEL = NET_KS
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] s
);
    logic [WIDTH-1:0] bit_g, bit_p;
    logic [WIDTH-1:0] grp_g, grp_p;
    logic [WIDTH-1:0] raw;

    mres_pg_pre #(.N(WIDTH)) u_pre (
        .op_x(a), .op_y(b), .bit_g(bit_g), .bit_p(bit_p)
    );

    mres_prefix_net #(.N(WIDTH), .NET_SEL(NET_SEL)) u_net (
        .bit_g(bit_g), .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p)
    );

    assign raw = bit_p ^ {grp_g[WIDTH-2:0], 1'b0};

    mres_excess_one #(.N(WIDTH)) u_inc (
        .raw(raw), .carry_out(grp_g[WIDTH-1]), .grp_p(grp_p), .res(s)
    );

    generate
        if (WIDTH <= 32) begin : g_chk
            always_comb begin
                assert_residue_R1: assert (64'(s) ==
                    ((64'(a) % ((64'd1 << WIDTH) - 1)) + (64'(b) % ((64'd1 << WIDTH) - 1)))
                    % ((64'd1 << WIDTH) - 1));
                assert_sum_raw_R5: assert (raw == WIDTH'(64'(a) + 64'(b)));
            end
        end
    endgenerate
endmodule

// File: tb/tb_mres_adder.sv
module tb_mres_adder;
    import mres_pkg::*;
    localparam int W = 16;
    localparam longint M = (64'd1 << W) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] a, b, s_ks, s_bk;
    int checks = 0;
    int errors = 0;

    mres_adder #(.WIDTH(W), .NET_SEL(NET_KS)) dut (.a(a), .b(b), .s(s_ks));
    mres_adder #(.WIDTH(W), .NET_SEL(NET_BK)) dut_bk (.a(a), .b(b), .s(s_bk));

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] x, input logic [W-1:0] y);
        longint t;
        t = ((longint'(x) % M) + (longint'(y) % M)) % M;
        return W'(t);
    endfunction

    task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
        logic [W-1:0] exp;
        @(posedge clk);
        #2;
        a = x;
        b = y;
        exp = ref_sum(x, y);
        @(negedge clk);
        checks++;
        if (s_ks !== exp) begin
            errors++;
            $display("FAIL %s KS a=%h b=%h got %h exp %h", req, x, y, s_ks, exp);
        end
        checks++;
        if (s_bk !== exp) begin
            errors++;
            $display("FAIL %s BK a=%h b=%h got %h exp %h", req, x, y, s_bk, exp);
        end
        checks++;
        if (s_ks === '1 || s_bk === '1) begin
            errors++;
            $display("FAIL R2 all-ones output a=%h b=%h got %h/%h exp not %h", x, y, s_ks, s_bk, {W{1'b1}});
        end
    endtask

    initial begin
        a = '0;
        b = '0;
        #5;
        checks++;
        if (s_ks !== '0) begin
            errors++;
            $display("FAIL R9 initial output got %h exp %h", s_ks, 16'h0);
        end
        run('0, '0, "R3");
        run(16'h1234, 16'hEDCB, "R4");
        run(16'h0001, 16'hFFFE, "R4");
        run(16'hFFFE, 16'hFFFE, "R5");
        run(16'h8000, 16'h8000, "R5");
        run(16'hFFFE, 16'h0002, "R5");
        run(16'hFFFF, 16'h0042, "R6");
        run(16'h0000, 16'hFFFF, "R6");
        run(16'hFFFF, 16'hFFFF, "R7");
        run(16'h0003, 16'h0004, "R1");
        for (int k = 0; k < W; k++) run(W'(1) << k, ~(W'(1) << k), "R4");
        for (int k = 0; k < 3000; k++) run(W'($urandom), W'($urandom), "R1/R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got hang exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule